// File: doc/BRIEF.md
# UART Interrupt Cause Combiner

This block sits beside one UART channel and merges its interrupt sources onto a single request line for the interrupt controller. It watches the transmit-buffer-empty level, the transmitter busy level, the receive-buffer fill level and three one-cycle receive error pulses (parity, framing, overrun). Four causes are each gated by their own enable bit: transmit buffer empty, transmission finished, receive buffer full and receive error.

Software programs the enables and a receive threshold select through a small register interface. It reads a status register to find out which cause is pending. The transmission-finished flag and the three error flags are sticky and are cleared by writing ones. The buffer flags are live copies of the core's levels. The receive-full cause fires on one stored entry or, when the threshold select is set, only on two. The request output is a registered level.

Top module: `uart_irq_merge`

## Requirements
- R1: While `rst` is high, every enable, the threshold select and every sticky flag go to 0. `irq` and `reg_rdata` are 0 after the first clock edge with `rst` high.
- R2: A write to offset 0 stores the control bits: bit 0 enables tx-empty, bit 1 enables tx-done, bit 2 enables rx-full, bit 3 enables rx-error, bit 4 selects the two-entry threshold. Reading offset 0 returns these five bits, and all higher bits read 0.
- R3: When tx-empty is enabled and `tx_empty` is 1, `irq` is 1.
- R4: The tx-done flag (status bit 1) is set on the clock edge that first sees `tx_busy` at 0 after it was 1. When tx-done is enabled, `irq` rises on that same edge.
- R5: With the threshold select at 0, the rx-full cause is active when `rx_level` is 1 or more. With the select at 1, it is active only when `rx_level` is 2 or more.
- R6: A pulse on `par_err`, `frm_err` or `ovr_err` sets status bit 4, 5 or 6 respectively, whatever the enables are. When rx-error is enabled, `irq` rises on that same edge.
- R7: Writing offset 4 with a 1 in bit 1, 4, 5 or 6 clears that sticky flag. Zeros in those bits, and any value in bits 0, 2 and 3, leave the flags unchanged.
- R8: If a set event and a clear write hit the same flag on the same edge, the flag ends up set.
- R9: `irq` after each edge is the OR of the enabled causes, using the control bits and flags as updated on that edge and the live inputs sampled on that edge. With every cause disabled, `irq` is 0.
- R10: Status bit 0 is `tx_empty`, bit 2 is (`rx_level` >= 1) and bit 3 is (`rx_level` >= 2). All three are live and not stored.
- R11: `reg_rdata` is registered. After an edge it holds the register that `reg_addr` selected at that edge, as it stood before that edge. Offsets other than 0 and 4 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | AW | Register byte offset |
| reg_wdata | input | DW | Write data |
| reg_rdata | output | DW | Registered read data |
| tx_empty | input | 1 | Transmit buffer empty level from the core |
| tx_busy | input | 1 | Transmitter busy level from the core |
| rx_level | input | 2 | Receive buffer entry count (0 to 2) |
| par_err | input | 1 | Parity error pulse |
| frm_err | input | 1 | Framing error pulse |
| ovr_err | input | 1 | Overrun error pulse |
| irq | output | 1 | Combined interrupt request level |

## Verification
The checker evaluates these properties every cycle:
- reset clearing;
- flag setting on a busy fall or an error pulse;
- clear-by-write when no set event competes;
- the silence of `irq` when every cause is masked;
- the tx-empty and rx-full threshold responses.

The bench covers what only sequences can show. It sweeps all 32 control values against every transmit and receive level, and checks each `irq` result against an arithmetic model. It also covers the effect of writing zeros or non-sticky bits to the status register, set-over-clear collisions, and enabling or disabling a cause while its flag is already pending.

// File: rtl/uirq_pkg.sv
package uirq_pkg;
  localparam int CTRL_W   = 5;
  localparam int STAT_W   = 7;
  localparam int STICKY_N = 4;

  // control bit positions
  localparam int C_TXE  = 0;
  localparam int C_DONE = 1;
  localparam int C_RXF  = 2;
  localparam int C_ERR  = 3;
  localparam int C_TWO  = 4;

  // status bit positions
  localparam int S_TXE  = 0;
  localparam int S_DONE = 1;
  localparam int S_RX1  = 2;
  localparam int S_RX2  = 3;
  localparam int S_PAR  = 4;
  localparam int S_FRM  = 5;
  localparam int S_OVR  = 6;

  // sticky flag index inside the flag vector
  localparam int F_DONE = 0;
  localparam int F_PAR  = 1;
  localparam int F_FRM  = 2;
  localparam int F_OVR  = 3;
endpackage

// File: rtl/uirq_ctrl_reg.sv
module uirq_ctrl_reg #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         we,
  input  logic [W-1:0] din,
  output logic [W-1:0] q,
  output logic [W-1:0] nx
);
  always_comb nx = we ? din : q;

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= nx;
  end
endmodule

// File: rtl/uirq_sticky_flags.sv
module uirq_sticky_flags #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_evt,
  input  logic [N-1:0] clr_req,
  output logic [N-1:0] q,
  output logic [N-1:0] nx
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    // a set event overrides a clear on the same edge
    always_comb nx[i] = set_evt[i] | (q[i] & ~clr_req[i]);

    always_ff @(posedge clk) begin
      if (rst) q[i] <= 1'b0;
      else     q[i] <= nx[i];
    end
  end
endmodule

// File: rtl/uirq_req_merge.sv
module uirq_req_merge
  import uirq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [CTRL_W-1:0] ctrl,
  input  logic              tx_empty,
  input  logic              rx_one,
  input  logic              rx_two,
  input  logic              done_flag,
  input  logic [2:0]        err_flags,
  output logic              irq
);
  logic [3:0] cause;

  always_comb begin
    cause[0] = ctrl[C_TXE]  & tx_empty;
    cause[1] = ctrl[C_DONE] & done_flag;
    cause[2] = ctrl[C_RXF]  & (ctrl[C_TWO] ? rx_two : rx_one);
    cause[3] = ctrl[C_ERR]  & (|err_flags);
  end

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= |cause;
  end
endmodule

// File: rtl/uart_irq_merge.sv
module uart_irq_merge
  import uirq_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          reg_wr,
  input  logic [AW-1:0] reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic          tx_empty,
  input  logic          tx_busy,
  input  logic [1:0]    rx_level,
  input  logic          par_err,
  input  logic          frm_err,
  input  logic          ovr_err,
  output logic          irq
);
  localparam logic [AW-1:0] CTRL_OFS = AW'(0);
  localparam logic [AW-1:0] STAT_OFS = AW'(4);

  logic                wr_ctrl, wr_stat;
  logic [CTRL_W-1:0]   ctrl_q, ctrl_nx;
  logic [STICKY_N-1:0] flag_q, flag_nx, set_evt, clr_req;
  logic                busy_q, rx_one, rx_two;
  logic [STAT_W-1:0]   stat;
  logic                unused_wdata;

  assign wr_ctrl      = reg_wr && (reg_addr == CTRL_OFS);
  assign wr_stat      = reg_wr && (reg_addr == STAT_OFS);
  assign unused_wdata = ^reg_wdata[DW-1:STAT_W];

  uirq_ctrl_reg #(.W(CTRL_W)) u_ctrl (
    .clk (clk),
    .rst (rst),
    .we  (wr_ctrl),
    .din (reg_wdata[CTRL_W-1:0]),
    .q   (ctrl_q),
    .nx  (ctrl_nx)
  );

  // busy history, no reset needed: only an edge detector
  always_ff @(posedge clk) busy_q <= tx_busy;

  always_comb begin
    set_evt[F_DONE] = busy_q & ~tx_busy;
    set_evt[F_PAR]  = par_err;
    set_evt[F_FRM]  = frm_err;
    set_evt[F_OVR]  = ovr_err;
    clr_req[F_DONE] = wr_stat & reg_wdata[S_DONE];
    clr_req[F_PAR]  = wr_stat & reg_wdata[S_PAR];
    clr_req[F_FRM]  = wr_stat & reg_wdata[S_FRM];
    clr_req[F_OVR]  = wr_stat & reg_wdata[S_OVR];
  end

  uirq_sticky_flags #(.N(STICKY_N)) u_flags (
    .clk     (clk),
    .rst     (rst),
    .set_evt (set_evt),
    .clr_req (clr_req),
    .q       (flag_q),
    .nx      (flag_nx)
  );

  assign rx_one = (rx_level != 2'd0);
  assign rx_two = rx_level[1];

  uirq_req_merge u_req (
    .clk       (clk),
    .rst       (rst),
    .ctrl      (ctrl_nx),
    .tx_empty  (tx_empty),
    .rx_one    (rx_one),
    .rx_two    (rx_two),
    .done_flag (flag_nx[F_DONE]),
    .err_flags ({flag_nx[F_OVR], flag_nx[F_FRM], flag_nx[F_PAR]}),
    .irq       (irq)
  );

  always_comb begin
    stat         = '0;
    stat[S_TXE]  = tx_empty;
    stat[S_DONE] = flag_q[F_DONE];
    stat[S_RX1]  = rx_one;
    stat[S_RX2]  = rx_two;
    stat[S_PAR]  = flag_q[F_PAR];
    stat[S_FRM]  = flag_q[F_FRM];
    stat[S_OVR]  = flag_q[F_OVR];
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else begin
      case (reg_addr)
        CTRL_OFS: reg_rdata <= DW'(ctrl_q);
        STAT_OFS: reg_rdata <= DW'(stat);
        default:  reg_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/uart_irq_merge_chk.sv
module uart_irq_merge_chk #(
  parameter int DW = 8,
  parameter int AW = 3
) (
  input logic          clk,
  input logic          rst,
  input logic          reg_wr,
  input logic [AW-1:0] reg_addr,
  input logic [DW-1:0] reg_wdata,
  input logic          tx_empty,
  input logic          tx_busy,
  input logic [1:0]    rx_level,
  input logic          par_err,
  input logic          irq,
  input logic [4:0]    ctrl_q,
  input logic [3:0]    flag_q
);
  assert_reset_clears_R1: assert property (@(posedge clk)
    rst |=> (!irq && ctrl_q == 5'd0 && flag_q == 4'd0));

  assert_txe_request_R3: assert property (@(posedge clk) disable iff (rst)
    (!reg_wr && ctrl_q[0] && tx_empty) |=> irq);

  assert_done_on_fall_R4: assert property (@(posedge clk) disable iff (rst)
    (!tx_busy && $past(tx_busy)) |=> flag_q[0]);

  assert_rx_one_R5: assert property (@(posedge clk) disable iff (rst)
    (!reg_wr && ctrl_q[2] && !ctrl_q[4] && rx_level != 2'd0) |=> irq);

  assert_rx_two_only_R5: assert property (@(posedge clk) disable iff (rst)
    (!reg_wr && ctrl_q == 5'b10100 && rx_level < 2'd2) |=> !irq);

  assert_par_sets_R6: assert property (@(posedge clk) disable iff (rst)
    par_err |=> flag_q[1]);

  assert_par_clears_R7: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr == AW'(4) && reg_wdata[4] && !par_err) |=> !flag_q[1]);

  assert_masked_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    (ctrl_q[3:0] == 4'd0) |-> !irq);
endmodule

bind uart_irq_merge uart_irq_merge_chk #(.DW(DW), .AW(AW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .reg_wr    (reg_wr),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .tx_empty  (tx_empty),
  .tx_busy   (tx_busy),
  .rx_level  (rx_level),
  .par_err   (par_err),
  .irq       (irq),
  .ctrl_q    (ctrl_q),
  .flag_q    (flag_q)
);

// File: tb/uart_irq_merge_test.sv
module uart_irq_merge_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       reg_wr = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       tx_empty = 1'b0, tx_busy = 1'b0;
  logic [1:0] rx_level = 2'd0;
  logic       par_err = 1'b0, frm_err = 1'b0, ovr_err = 1'b0;
  logic       irq;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  uart_irq_merge uut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tx_empty(tx_empty),
    .tx_busy(tx_busy), .rx_level(rx_level), .par_err(par_err),
    .frm_err(frm_err), .ovr_err(ovr_err), .irq(irq)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    tick();
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(input logic [2:0] a, output int v);
    reg_wr = 1'b0; reg_addr = a;
    tick();
    v = int'(reg_rdata);
  endtask

  task automatic pulse(input int which);
    if (which == 0) par_err = 1'b1;
    if (which == 1) frm_err = 1'b1;
    if (which == 2) ovr_err = 1'b1;
    tick();
    par_err = 1'b0; frm_err = 1'b0; ovr_err = 1'b0;
  endtask

  function automatic int model_irq(input int c, input int te, input int rc);
    int rxf;
    rxf = ((c >> 4) & 1) ? (rc >= 2) : (rc >= 1);
    return ((c & 1) & te) | (((c >> 2) & 1) & rxf);
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int v;
    tick(); tick();
    rst = 1'b0;
    // R1: reset state
    check("R1 irq", int'(irq), 0);
    check("R1 rdata", int'(reg_rdata), 0);
    rd(3'd0, v); check("R1 ctrl", v, 0);
    rd(3'd4, v); check("R1 status", v, 0);

    // R2: every control value, upper bits read as 0
    for (int c = 0; c < 32; c++) begin
      wr(3'd0, 8'(c | 8'hE0));
      rd(3'd0, v); check("R2 ctrl readback", v, c);
    end
    // R11: unmapped offsets
    rd(3'd2, v); check("R11 unmapped", v, 0);
    rd(3'd6, v); check("R11 unmapped", v, 0);

    // R3 R5 R9: full sweep, no sticky flags pending
    for (int c = 0; c < 32; c++) begin
      wr(3'd0, 8'(c));
      for (int te = 0; te < 2; te++) begin
        for (int rc = 0; rc < 3; rc++) begin
          tx_empty = 1'(te); rx_level = 2'(rc);
          tick();
          check("R3 R5 R9 sweep irq", int'(irq), model_irq(c, te, rc));
        end
      end
    end

    // R10: live status levels
    tx_empty = 1'b1; rx_level = 2'd2;
    rd(3'd4, v); check("R10 status live", v, 8'h0D);
    tx_empty = 1'b0; rx_level = 2'd1;
    rd(3'd4, v); check("R10 status live", v, 8'h04);
    rx_level = 2'd0;

    // R4: tx-done flag on busy fall
    wr(3'd0, 8'h02);
    tx_busy = 1'b1; tick();
    check("R4 busy high no irq", int'(irq), 0);
    tx_busy = 1'b0; tick();
    check("R4 irq on fall", int'(irq), 1);
    tick();
    check("R4 sticky irq", int'(irq), 1);
    rd(3'd4, v); check("R4 status done", v, 8'h02);
    // R7: zeros and non-sticky bits do nothing
    wr(3'd4, 8'h00);
    check("R7 write zero keeps", int'(irq), 1);
    wr(3'd4, 8'h0D);
    check("R7 live bits ignored", int'(irq), 1);
    rd(3'd4, v); check("R7 flag still set", v, 8'h02);
    wr(3'd4, 8'h02);
    check("R7 clear drops irq", int'(irq), 0);
    rd(3'd4, v); check("R7 status cleared", v, 0);

    // R8: fall and clear on same edge
    tx_busy = 1'b1; tick();
    tx_busy = 1'b0;
    wr(3'd4, 8'h02);
    check("R8 set wins irq", int'(irq), 1);
    rd(3'd4, v); check("R8 set wins flag", v, 8'h02);
    wr(3'd4, 8'h02);

    // R6: each error flag with rx-error enabled
    wr(3'd0, 8'h08);
    for (int e = 0; e < 3; e++) begin
      pulse(e);
      check("R6 irq on error", int'(irq), 1);
      rd(3'd4, v); check("R6 error bit", v, 1 << (4 + e));
      wr(3'd4, 8'(1 << (4 + e)));
      check("R7 error clear", int'(irq), 0);
    end

    // R9: flag set while masked, then enable/disable
    wr(3'd0, 8'h00);
    pulse(0);
    check("R9 masked no irq", int'(irq), 0);
    rd(3'd4, v); check("R6 flag set while masked", v, 8'h10);
    wr(3'd0, 8'h08);
    check("R9 enable raises irq", int'(irq), 1);
    wr(3'd0, 8'h00);
    check("R9 disable drops irq", int'(irq), 0);
    wr(3'd4, 8'h10);

    // R8: error pulse with clear on same edge
    frm_err = 1'b1;
    wr(3'd4, 8'h20);
    frm_err = 1'b0;
    rd(3'd4, v); check("R8 error set wins", v, 8'h20);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule